// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox with Busy Lock

This block holds one single-entry mailbox per CPU for interrupt messages that arrive over a system bus. Each message names a target CPU and carries a 5-bit source ID and two 64-bit data words. When the target's mailbox is free and the interrupt post channel can take a request, the block stores the message, locks the mailbox and posts an interrupt to that CPU. The post uses one programmable vector that all mailboxes share. A message for a locked mailbox is refused in the same cycle, so the sender can try again later.

Software sees the mailboxes through a small register window. It can address an entry by CPU index. It can also use a self-alias, which resolves to the entry of the CPU that issues the access. Software reads both data words and a status word that holds the lock flag and the source ID. It writes the status word to release the mailbox.

Address map (byte addresses, bits 2:0 ignored):
- 0x000 + 8·n: data word 0 of CPU n.
- 0x100 + 8·n: data word 1 of CPU n.
- 0x200 + 8·n: status word of CPU n.
- 0x300, 0x308, 0x310: data word 0, data word 1 and status of the requesting CPU.
- 0x400: the shared vector.

Top module: `cpu_mailbox`

## Requirements
- R1: After reset every mailbox is unlocked, with source ID and both data words zero. The shared vector is 0 and `post_valid` is low.
- R2: An accepted message for CPU n sets that CPU's lock flag and stores the source and both data words. The stored data reads back at 0x000+8n and 0x100+8n. The status word at 0x200+8n reads back with the lock flag in bit 5 and the source ID in bits 4:0.
- R3: In the acceptance cycle, `post_valid` is high, `post_cpu` equals the message's target and `post_vec` equals the shared vector. A write to 0x400 loads the vector from data bits 5:0, and a read of 0x400 returns it zero-extended.
- R4: A message for a locked mailbox is rejected (`msg_reject` high, `msg_accept` low), and the stored contents of that mailbox stay unchanged.
- R5: A message is accepted only while `post_ready` is high. Otherwise it is rejected and changes no state.
- R6: A write to a status word loads the lock flag from data bit 5 and ignores every other data bit. The stored source ID is kept.
- R7: If software writes a CPU's status word in the same cycle as a message for that CPU arrives, the message is rejected in that cycle.
- R8: The alias addresses 0x300, 0x308 and 0x310 read and write the entry selected by `reg_cpu`.
- R9: A message whose target is NUM_CPU or above is rejected, with `post_valid` low. A register index or alias CPU of NUM_CPU or above reads as zero, and a write to it has no effect.
- R10: `reg_rdvalid` is high in the cycle after a cycle with `reg_rd` high. `reg_rdata` then holds the addressed value as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Incoming message present |
| msg_cpu | input | 5 | Target CPU of the message |
| msg_src | input | 5 | Source ID of the message |
| msg_d0 | input | DATA_W | First data word |
| msg_d1 | input | DATA_W | Second data word |
| msg_accept | output | 1 | Message taken this cycle |
| msg_reject | output | 1 | Message refused this cycle; the sender must retry |
| post_valid | output | 1 | Interrupt post request |
| post_cpu | output | 5 | CPU to interrupt |
| post_vec | output | 6 | Vector to post |
| post_ready | input | 1 | Post channel can take a request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_cpu | input | 5 | CPU issuing the register access |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, one cycle after the read |
| reg_rdvalid | output | 1 | Read data valid |

## Verification
The bench builds the block with NUM_CPU = 4 and the default 64-bit data words. This leaves message targets, register indices and alias CPUs from 4 to 31 outside the mailbox array, so the out-of-range paths can be driven through ordinary port values. The 64-bit words let the bench use distinct patterns in the upper and lower halves, which shows that both words are stored and returned in full. Four entries are enough to lock one mailbox while its neighbours stay free, which shows that each lock acts on its own entry only.

// File: rtl/mbx_pkg.sv
// Package: shared constants and types of the per-CPU mailbox.
// Assumes byte addresses of 12 bits; bits 11:8 pick a region and bits 7:3 a slot.
package mbx_pkg;
    localparam int IDX_W    = 5;   // CPU index width (up to 32 CPUs)
    localparam int SRC_W    = 5;   // source ID width
    localparam int VEC_W    = 6;   // shared vector width
    localparam int ADDR_W   = 12;  // register address width
    localparam int LOCK_BIT = 5;   // lock flag position in the status word

    localparam logic [3:0] RGN_D0    = 4'h0;
    localparam logic [3:0] RGN_D1    = 4'h1;
    localparam logic [3:0] RGN_STAT  = 4'h2;
    localparam logic [3:0] RGN_ALIAS = 4'h3;
    localparam logic [3:0] RGN_VEC   = 4'h4;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_D0,
        KIND_D1,
        KIND_STAT,
        KIND_VEC
    } reg_kind_t;
endpackage

// File: rtl/mbx_decode.sv
// Module: mbx_decode
// Turns a register address and the requesting CPU into an access kind and an
// entry index. Alias slots take the requesting CPU as index. An index that is
// not below NUM_CPU, or an unmapped address, yields KIND_NONE.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  req_cpu,
    output reg_kind_t         kind,
    output logic [IDX_W-1:0]  idx
);
    logic [3:0]       region;
    logic [IDX_W-1:0] slot;
    reg_kind_t        raw_kind;
    logic             idx_ok;

    assign region = addr[ADDR_W-1:8];
    assign slot   = addr[7:3];

    // Classify the address by region and slot.
    always_comb begin
        raw_kind = KIND_NONE;
        idx      = slot;
        case (region)
            RGN_D0:   raw_kind = KIND_D0;
            RGN_D1:   raw_kind = KIND_D1;
            RGN_STAT: raw_kind = KIND_STAT;
            RGN_ALIAS: begin
                idx = req_cpu;
                case (slot)
                    5'd0:    raw_kind = KIND_D0;
                    5'd1:    raw_kind = KIND_D1;
                    5'd2:    raw_kind = KIND_STAT;
                    default: raw_kind = KIND_NONE;
                endcase
            end
            RGN_VEC:  raw_kind = (slot == '0) ? KIND_VEC : KIND_NONE;
            default:  raw_kind = KIND_NONE;
        endcase
    end

    assign idx_ok = (int'(idx) < NUM_CPU);

    // Drop entry accesses whose index lies outside the array.
    always_comb begin
        if (raw_kind == KIND_VEC || (raw_kind != KIND_NONE && idx_ok))
            kind = raw_kind;
        else
            kind = KIND_NONE;
    end
endmodule

// File: rtl/mbx_slot.sv
// Module: mbx_slot
// One CPU's mailbox entry: a lock flag, the source ID and two data words.
// A software status write takes priority over a message load. The parent
// guarantees that both never fall in the same cycle.
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SRC_W-1:0]  load_src,
    input  logic [DATA_W-1:0] load_d0,
    input  logic [DATA_W-1:0] load_d1,
    input  logic              sw_wr,
    input  logic              sw_lock,
    output logic              lock_q,
    output logic [SRC_W-1:0]  src_q,
    output logic [DATA_W-1:0] d0_q,
    output logic [DATA_W-1:0] d1_q
);
    // Lock flag: set by software or by an accepted message.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (sw_wr)
            lock_q <= sw_lock;
        else if (load)
            lock_q <= 1'b1;
    end

    // Message payload: captured only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            d0_q  <= '0;
            d1_q  <= '0;
        end else if (load) begin
            src_q <= load_src;
            d0_q  <= load_d0;
            d1_q  <= load_d1;
        end
    end
endmodule

// File: rtl/mbx_rdmux.sv
// Module: mbx_rdmux
// Selects read data for a decoded access. It returns zero for KIND_NONE.
// The status word holds the lock flag at LOCK_BIT and the source ID below it.
module mbx_rdmux
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int DATA_W  = 64
) (
    input  reg_kind_t         kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [NUM_CPU-1:0] lock_vec,
    input  logic [SRC_W-1:0]  src_arr [NUM_CPU],
    input  logic [DATA_W-1:0] d0_arr  [NUM_CPU],
    input  logic [DATA_W-1:0] d1_arr  [NUM_CPU],
    input  logic [VEC_W-1:0]  vec,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] d0_sel;
    logic [DATA_W-1:0] d1_sel;
    logic [DATA_W-1:0] stat_sel;

    // Gather the indexed entry by one-hot OR across all slots.
    always_comb begin
        d0_sel   = '0;
        d1_sel   = '0;
        stat_sel = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (idx == IDX_W'(c)) begin
                d0_sel   = d0_sel | d0_arr[c];
                d1_sel   = d1_sel | d1_arr[c];
                stat_sel = stat_sel | DATA_W'({lock_vec[c], src_arr[c]});
            end
        end
    end

    // Pick the word for the access kind.
    always_comb begin
        case (kind)
            KIND_D0:   rdata = d0_sel;
            KIND_D1:   rdata = d1_sel;
            KIND_STAT: rdata = stat_sel;
            KIND_VEC:  rdata = DATA_W'(vec);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/cpu_mailbox.sv
// Module: cpu_mailbox
// Holds a single-entry mailbox with a lock for each CPU. A message is accepted
// when its target exists, the target's lock is clear, software is not writing
// that target's status word this cycle, and post_ready is high. Acceptance
// posts an interrupt with the shared vector. Accept and reject are
// combinational in the message cycle. Register reads return one cycle later.
// Assumes NUM_CPU <= 32 and that reg_wr and reg_rd address one register.
module cpu_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [IDX_W-1:0]  msg_cpu,
    input  logic [SRC_W-1:0]  msg_src,
    input  logic [DATA_W-1:0] msg_d0,
    input  logic [DATA_W-1:0] msg_d1,
    output logic              msg_accept,
    output logic              msg_reject,
    output logic              post_valid,
    output logic [IDX_W-1:0]  post_cpu,
    output logic [VEC_W-1:0]  post_vec,
    input  logic              post_ready,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [IDX_W-1:0]  reg_cpu,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rdvalid
);
    reg_kind_t         acc_kind;
    logic [IDX_W-1:0]  acc_idx;
    logic              stat_wr;
    logic              vec_wr;
    logic [VEC_W-1:0]  vec_q;
    logic [NUM_CPU-1:0] busy_vec;
    logic [NUM_CPU-1:0] msg_hot;
    logic [NUM_CPU-1:0] sw_hot;
    logic [SRC_W-1:0]  src_arr [NUM_CPU];
    logic [DATA_W-1:0] d0_arr  [NUM_CPU];
    logic [DATA_W-1:0] d1_arr  [NUM_CPU];
    logic              target_free;
    logic [DATA_W-1:0] rd_next;

    mbx_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .addr    (reg_addr),
        .req_cpu (reg_cpu),
        .kind    (acc_kind),
        .idx     (acc_idx)
    );

    assign stat_wr = reg_wr && (acc_kind == KIND_STAT);
    assign vec_wr  = reg_wr && (acc_kind == KIND_VEC);

    // One mailbox entry per CPU, with its one-hot selects.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_slot
        assign msg_hot[c] = (msg_cpu == IDX_W'(c));
        assign sw_hot[c]  = stat_wr && (acc_idx == IDX_W'(c));

        mbx_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (msg_accept && msg_hot[c]),
            .load_src (msg_src),
            .load_d0  (msg_d0),
            .load_d1  (msg_d1),
            .sw_wr    (sw_hot[c]),
            .sw_lock  (reg_wdata[LOCK_BIT]),
            .lock_q   (busy_vec[c]),
            .src_q    (src_arr[c]),
            .d0_q     (d0_arr[c]),
            .d1_q     (d1_arr[c])
        );
    end

    // Free target: it exists, it is unlocked and software is not writing its status word.
    assign target_free = (|msg_hot) && !(|(msg_hot & busy_vec)) && !(|(msg_hot & sw_hot));

    assign post_valid = msg_valid && target_free;
    assign post_cpu   = msg_cpu;
    assign post_vec   = vec_q;
    assign msg_accept = post_valid && post_ready;
    assign msg_reject = msg_valid && !msg_accept;

    // Shared vector register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (vec_wr)
            vec_q <= reg_wdata[VEC_W-1:0];
    end

    mbx_rdmux #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_rd (
        .kind     (acc_kind),
        .idx      (acc_idx),
        .lock_vec (busy_vec),
        .src_arr  (src_arr),
        .d0_arr   (d0_arr),
        .d1_arr   (d1_arr),
        .vec      (vec_q),
        .rdata    (rd_next)
    );

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdvalid <= 1'b0;
            reg_rdata   <= '0;
        end else begin
            reg_rdvalid <= reg_rd;
            if (reg_rd)
                reg_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/cpu_mailbox_chk.sv
// Module: cpu_mailbox_chk
// Temporal checks on the mailbox's ports and on the lock flags its slots drive.
// Bound into every cpu_mailbox instance.
module cpu_mailbox_chk
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int DATA_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_valid,
    input logic [IDX_W-1:0]  msg_cpu,
    input logic              msg_accept,
    input logic              post_valid,
    input logic              post_ready,
    input logic [VEC_W-1:0]  post_vec,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_rdvalid,
    input logic [NUM_CPU-1:0] busy_vec
);
    logic [IDX_W-1:0] last_cpu;
    logic             busy_at_msg;
    logic             busy_at_last;
    logic             in_range;
    logic             vec_hit;
    logic             stat_hit_msg;

    // Remember the previous message target.
    always_ff @(posedge clk) begin
        last_cpu <= msg_cpu;
    end

    // Lock flag of the current and previous targets.
    always_comb begin
        busy_at_msg  = 1'b0;
        busy_at_last = 1'b0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (msg_cpu == IDX_W'(c))  busy_at_msg  = busy_vec[c];
            if (last_cpu == IDX_W'(c)) busy_at_last = busy_vec[c];
        end
    end

    assign in_range     = int'(msg_cpu) < NUM_CPU;
    assign vec_hit      = reg_wr && (reg_addr[ADDR_W-1:3] == {RGN_VEC, 5'd0});
    assign stat_hit_msg = reg_wr && (reg_addr[ADDR_W-1:3] == {RGN_STAT, msg_cpu});

    AST_LOCK_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && busy_at_msg) |-> !msg_accept); // R4
    AST_ACCEPT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        msg_accept |=> busy_at_last); // R2
    AST_READY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !post_ready |-> !msg_accept); // R5
    AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        vec_hit |=> (post_vec == $past(reg_wdata[VEC_W-1:0]))); // R3
    AST_SAME_CYCLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && stat_hit_msg) |-> !msg_accept); // R7
    AST_RANGE_NO_POST: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !in_range) |-> !post_valid); // R9
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rdvalid); // R10
endmodule

bind cpu_mailbox cpu_mailbox_chk #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/cpu_mailbox_tb.sv
// Directed bench for cpu_mailbox: one task per scenario, each checking its own results.
module cpu_mailbox_tb;
    import mbx_pkg::*;

    localparam int NCPU = 4;
    localparam int DW   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msg_valid = 1'b0;
    logic [IDX_W-1:0]  msg_cpu = '0;
    logic [SRC_W-1:0]  msg_src = '0;
    logic [DW-1:0]     msg_d0 = '0;
    logic [DW-1:0]     msg_d1 = '0;
    logic              msg_accept;
    logic              msg_reject;
    logic              post_valid;
    logic [IDX_W-1:0]  post_cpu;
    logic [VEC_W-1:0]  post_vec;
    logic              post_ready = 1'b1;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [IDX_W-1:0]  reg_cpu = '0;
    logic [DW-1:0]     reg_wdata = '0;
    logic [DW-1:0]     reg_rdata;
    logic              reg_rdvalid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cpu_mailbox #(.NUM_CPU(NCPU), .DATA_W(DW)) u_dut (.*);

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Register read; also checks the one-cycle return (R10).
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [IDX_W-1:0] who, output logic [DW-1:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; reg_cpu = who;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        chk("R10 rdvalid", DW'(reg_rdvalid), 1);
        d = reg_rdata;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [IDX_W-1:0] who, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_cpu = who; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    // Offer one message; returns accept and the post fields seen in that cycle.
    task automatic send(input logic [IDX_W-1:0] c, input logic [SRC_W-1:0] s,
                        input logic [DW-1:0] a, input logic [DW-1:0] b, input logic rdy,
                        output logic acc, output logic rej, output logic pv,
                        output logic [IDX_W-1:0] pc, output logic [VEC_W-1:0] pvec);
        @(negedge clk);
        msg_valid = 1'b1; msg_cpu = c; msg_src = s; msg_d0 = a; msg_d1 = b; post_ready = rdy;
        #1;
        acc = msg_accept; rej = msg_reject; pv = post_valid; pc = post_cpu; pvec = post_vec;
        @(posedge clk); #1;
        msg_valid = 1'b0; post_ready = 1'b1;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        chk("R1 post_valid", DW'(post_valid), 0);
        for (int c = 0; c < NCPU; c++) begin
            rd(ADDR_W'(12'h200 + 8*c), '0, d); chk("R1 status", d, 0);
            rd(ADDR_W'(12'h000 + 8*c), '0, d); chk("R1 data0", d, 0);
        end
        rd(12'h400, '0, d); chk("R1 vector", d, 0);
    endtask

    task automatic t_vector();
        logic [DW-1:0] d;
        wr(12'h400, '0, 64'hFFFF_FFFF_FFFF_FFEA);
        rd(12'h400, '0, d); chk("R3 vector readback", d, 64'h2A);
    endtask

    task automatic t_accept();
        logic acc, rej, pv; logic [IDX_W-1:0] pc; logic [VEC_W-1:0] pvec; logic [DW-1:0] d;
        send(5'd1, 5'h13, 64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_5555_AAAA, 1'b1, acc, rej, pv, pc, pvec);
        chk("R3 accept", DW'(acc), 1);
        chk("R3 post_valid", DW'(pv), 1);
        chk("R3 post_cpu", DW'(pc), 1);
        chk("R3 post_vec", DW'(pvec), 64'h2A);
        rd(12'h008, '0, d); chk("R2 data0", d, 64'hDEAD_BEEF_0123_4567);
        rd(12'h108, '0, d); chk("R2 data1", d, 64'h89AB_CDEF_5555_AAAA);
        rd(12'h208, '0, d); chk("R2 status", d, 64'h33);
        rd(12'h210, '0, d); chk("R2 neighbour free", d, 0);
    endtask

    task automatic t_locked();
        logic acc, rej, pv; logic [IDX_W-1:0] pc; logic [VEC_W-1:0] pvec; logic [DW-1:0] d;
        send(5'd1, 5'h05, 64'h1111, 64'h2222, 1'b1, acc, rej, pv, pc, pvec);
        chk("R4 reject", DW'(rej), 1);
        chk("R4 no accept", DW'(acc), 0);
        rd(12'h008, '0, d); chk("R4 data0 kept", d, 64'hDEAD_BEEF_0123_4567);
        rd(12'h208, '0, d); chk("R4 status kept", d, 64'h33);
    endtask

    task automatic t_not_ready();
        logic acc, rej, pv; logic [IDX_W-1:0] pc; logic [VEC_W-1:0] pvec; logic [DW-1:0] d;
        send(5'd2, 5'h09, 64'h3333, 64'h4444, 1'b0, acc, rej, pv, pc, pvec);
        chk("R5 reject", DW'(rej), 1);
        rd(12'h210, '0, d); chk("R5 status unchanged", d, 0);
        rd(12'h010, '0, d); chk("R5 data0 unchanged", d, 0);
    endtask

    task automatic t_release();
        logic acc, rej, pv; logic [IDX_W-1:0] pc; logic [VEC_W-1:0] pvec; logic [DW-1:0] d;
        wr(12'h208, '0, 64'hFFFF_FFFF_FFFF_FFDF);
        rd(12'h208, '0, d); chk("R6 lock cleared, source kept", d, 64'h13);
        wr(12'h218, '0, 64'h20);
        rd(12'h218, '0, d); chk("R6 lock set by write", d, 64'h20);
        send(5'd3, 5'h01, 64'h1, 64'h2, 1'b1, acc, rej, pv, pc, pvec);
        chk("R6 set lock refuses", DW'(acc), 0);
    endtask

    task automatic t_conflict();
        logic acc, rej, pv; logic [IDX_W-1:0] pc; logic [VEC_W-1:0] pvec; logic [DW-1:0] d;
        send(5'd1, 5'h07, 64'h7777, 64'h8888, 1'b1, acc, rej, pv, pc, pvec);
        chk("R7 prep accept", DW'(acc), 1);
        wr(12'h208, '0, 64'h0);
        @(negedge clk);
        msg_valid = 1'b1; msg_cpu = 5'd1; msg_src = 5'h0A; msg_d0 = 64'h9999; msg_d1 = 64'hAAAA;
        reg_wr = 1'b1; reg_addr = 12'h208; reg_wdata = 64'h0;
        #1;
        chk("R7 same-cycle reject", DW'(msg_accept), 0);
        @(posedge clk); #1;
        msg_valid = 1'b0; reg_wr = 1'b0;
        rd(12'h208, '0, d); chk("R7 status after", d, 64'h07);
        rd(12'h008, '0, d); chk("R7 data unchanged", d, 64'h7777);
    endtask

    task automatic t_alias();
        logic acc, rej, pv; logic [IDX_W-1:0] pc; logic [VEC_W-1:0] pvec; logic [DW-1:0] d;
        send(5'd1, 5'h11, 64'hC0DE_0001, 64'hC0DE_0002, 1'b1, acc, rej, pv, pc, pvec);
        chk("R8 prep accept", DW'(acc), 1);
        rd(12'h300, 5'd1, d); chk("R8 alias data0", d, 64'hC0DE_0001);
        rd(12'h308, 5'd1, d); chk("R8 alias data1", d, 64'hC0DE_0002);
        rd(12'h310, 5'd1, d); chk("R8 alias status", d, 64'h31);
        rd(12'h310, 5'd3, d); chk("R8 alias other cpu", d, 64'h20);
        wr(12'h310, 5'd1, 64'h0);
        rd(12'h208, '0, d); chk("R8 alias release", d, 64'h11);
        rd(12'h218, '0, d); chk("R8 other cpu untouched", d, 64'h20);
    endtask

    task automatic t_range();
        logic acc, rej, pv; logic [IDX_W-1:0] pc; logic [VEC_W-1:0] pvec; logic [DW-1:0] d;
        send(5'd5, 5'h02, 64'h5, 64'h6, 1'b1, acc, rej, pv, pc, pvec);
        chk("R9 reject", DW'(rej), 1);
        chk("R9 no post", DW'(pv), 0);
        wr(12'h228, '0, 64'h20);
        rd(12'h228, '0, d); chk("R9 indexed read zero", d, 0);
        rd(12'h310, 5'd5, d); chk("R9 alias read zero", d, 0);
        for (int c = 0; c < 3; c++) begin
            rd(ADDR_W'(12'h200 + 8*c), '0, d);
            chk("R9 entries untouched", d, (c == 1) ? 64'h11 : 64'h0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_vector();
        t_accept();
        t_locked();
        t_not_ready();
        t_release();
        t_conflict();
        t_alias();
        t_range();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule